// File: doc/BRIEF.md
# Hybrid Barrier Wake-up Controller

This block manages one core's trip into and out of a low-power state while it waits at a barrier. When software arms it, the block takes the predicted stall time, the address of the barrier's lock line, a flag that says whether the chosen sleep state can snoop coherence traffic, and the entry and exit latencies of that state. If the state cannot snoop, the block first asks the cache to write back dirty data. It then waits out the entry latency and puts the core to sleep.

Two events can end the sleep, and the first one wins. One is a countdown loaded with the predicted stall, which tries to wake the core just before the barrier opens. The other is a snooped invalidation to the lock line, which puts a firm upper limit on how late the wake can be. After the exit latency, the block samples the release flag. If the barrier is still closed, the core spins on the flag until it opens. The block then offers a departure token. A predicted stall of zero skips sleep and goes straight to spinning.

The arm request is a valid/ready transfer. `arm_ready` is high only while the block is idle, so a new request is held off until the previous barrier has departed. The departure token is also valid/ready: `depart_valid` stays high, and the block stays in its departure phase, until the consumer raises `depart_ready`. Snoop, flush and release inputs are plain level or pulse signals and cannot be back-pressured.

Top module: `barrier_wake_ctrl`

## Requirements
- R1: After reset, `arm_ready` is 1, and `flush_req`, `core_sleep`, `spinning`, `depart_valid`, `wake_cause` and `early` are all 0.
- R2: `arm_ready` is high only when idle. An arm is taken on a cycle with `arm_valid && arm_ready`, and while a barrier is in progress `arm_ready` stays 0 up to and including the departure cycle.
- R3: An arm with `arm_stall` equal to 0 moves to residual spin in the next cycle. There is no flush and no sleep, and `wake_cause` and `early` stay 0.
- R4: When `arm_nosnoop` is 1 and the stall is not zero, `flush_req` goes high from the cycle after the arm and stays high up to and including the cycle in which `flush_done` is 1. Sleep entry follows. When `arm_nosnoop` is 0, there is no flush.
- R5: Sleep entry lasts `arm_enter_lat`+1 cycles. `core_sleep` is high during entry and during sleep.
- R6: With no matching invalidation, sleep lasts exactly `arm_stall` cycles and then the timer wakes the core. Timer wake sets `wake_cause` bit 0.
- R7: An invalidation matches when `inv_valid` is 1 and `inv_addr` bits [ADDR_W-1:LINE_OFS] equal those of the armed address, so the offset bits are ignored. A match during sleep ends sleep after that cycle and sets `wake_cause` bit 1. If it lands in the same cycle as timer expiry, both bits are set. Non-matching lines, and invalidations while idle, exiting, spinning or departing, have no effect.
- R8: A match during flush or sleep entry is latched. The core then sleeps for exactly one cycle, with `wake_cause` bit 1 set, plus bit 0 if the stall is 1.
- R9: Sleep exit lasts `arm_exit_lat`+1 cycles. `early` is set to 1 when `rel_flag` is 0 in the last exit cycle.
- R10: If `rel_flag` is 1 in the last exit cycle, departure follows at once. Otherwise the block spins with `spinning`=1 and departs in the cycle after the first cycle in which `rel_flag` is 1.
- R11: `depart_valid` stays high until a cycle with `depart_ready` set, and the block is idle in the next cycle.
- R12: `wake_cause` and `early` keep their values after departure until the next arm is taken, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| arm_valid | input | 1 | Arm request valid |
| arm_ready | output | 1 | Arm request accepted (idle) |
| arm_stall | input | STALL_W | Predicted stall cycles for the watchdog |
| arm_addr | input | ADDR_W | Barrier lock address |
| arm_nosnoop | input | 1 | Sleep state cannot snoop; flush first |
| arm_enter_lat | input | LAT_W | Sleep entry latency |
| arm_exit_lat | input | LAT_W | Sleep exit latency |
| flush_req | output | 1 | Ask cache to write back dirty lines |
| flush_done | input | 1 | Cache flush finished |
| inv_valid | input | 1 | Snooped invalidation present |
| inv_addr | input | ADDR_W | Address of snooped invalidation |
| rel_flag | input | 1 | Barrier flag shows release |
| core_sleep | output | 1 | Core entering or in sleep |
| spinning | output | 1 | Residual spin on barrier flag |
| wake_cause | output | 2 | Bit 0 timer, bit 1 invalidation |
| early | output | 1 | Core woke before release |
| depart_valid | output | 1 | Departure token valid |
| depart_ready | input | 1 | Departure token taken |

## Verification
The bench builds the block with a 3-bit stall, 1-bit latencies, 12-bit addresses and 16-byte lines. Every stall value from 0 to 7 and every combination of entry latency, exit latency and snoop mode can then be swept. For each one, a single invalidation is placed in every cycle from flush through exit, cycling through an exact hit, a hit on another offset in the same line, and a different line. Each placement runs once with an early release and once with a late release. That reaches every window boundary: a latched hit, a hit on the expiry cycle, and ignored hits after wake.

// File: rtl/bwc_pkg.sv
package bwc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_FLUSH, ST_ENTER, ST_SLEEP, ST_EXIT, ST_SPIN, ST_DEPART
  } bwc_state_e;
  localparam int CAUSE_W   = 2;
  localparam int CAUSE_TMR = 0;
  localparam int CAUSE_INV = 1;
endpackage

// File: rtl/bwc_watchdog.sv
module bwc_watchdog #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         run,
  output logic         fire
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (load)                cnt_q <= load_val;
    else if (run && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  // expiry on the last counted cycle of sleep
  assign fire = run && (cnt_q == W'(1));
endmodule

// File: rtl/bwc_phase_timer.sv
module bwc_phase_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load)            cnt_q <= load_val;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/bwc_line_match.sv
module bwc_line_match #(
  parameter int ADDR_W   = 32,
  parameter int LINE_OFS = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic              watch,
  input  logic              hold,
  input  logic              inv_valid,
  input  logic [ADDR_W-1:0] inv_addr,
  output logic              hit,
  output logic              pending
);
  localparam int TAG_W = ADDR_W - LINE_OFS;

  logic [TAG_W-1:0] tag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q   <= '0;
      pending <= 1'b0;
    end else if (capture) begin
      tag_q   <= cap_addr[ADDR_W-1:LINE_OFS];
      pending <= 1'b0;
    end else if (hold && hit) begin
      pending <= 1'b1;
    end
  end

  assign hit = watch && inv_valid && (inv_addr[ADDR_W-1:LINE_OFS] == tag_q);
endmodule

// File: rtl/barrier_wake_ctrl.sv
module barrier_wake_ctrl
  import bwc_pkg::*;
#(
  parameter int STALL_W  = 16,
  parameter int ADDR_W   = 32,
  parameter int LINE_OFS = 6,
  parameter int LAT_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                arm_valid,
  output logic                arm_ready,
  input  logic [STALL_W-1:0]  arm_stall,
  input  logic [ADDR_W-1:0]   arm_addr,
  input  logic                arm_nosnoop,
  input  logic [LAT_W-1:0]    arm_enter_lat,
  input  logic [LAT_W-1:0]    arm_exit_lat,
  output logic                flush_req,
  input  logic                flush_done,
  input  logic                inv_valid,
  input  logic [ADDR_W-1:0]   inv_addr,
  input  logic                rel_flag,
  output logic                core_sleep,
  output logic                spinning,
  output logic [CAUSE_W-1:0]  wake_cause,
  output logic                early,
  output logic                depart_valid,
  input  logic                depart_ready
);
  bwc_state_e state_q, state_d;

  logic [LAT_W-1:0]   ent_lat_q, ext_lat_q;
  logic [CAUSE_W-1:0] cause_q;
  logic               early_q;

  logic             accept;
  logic             ph_load, ph_done;
  logic [LAT_W-1:0] ph_val;
  logic             wd_run, wd_fire;
  logic             inv_hit, inv_pend;
  logic             watch, hold, wake;

  assign accept = arm_valid && arm_ready;
  assign watch  = (state_q == ST_FLUSH) || (state_q == ST_ENTER) || (state_q == ST_SLEEP);
  assign hold   = (state_q == ST_FLUSH) || (state_q == ST_ENTER);
  assign wd_run = (state_q == ST_SLEEP);
  assign wake   = wd_run && (inv_pend || inv_hit || wd_fire);

  bwc_watchdog #(.W(STALL_W)) i_wd (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val (arm_stall),
    .run      (wd_run),
    .fire     (wd_fire)
  );

  bwc_phase_timer #(.W(LAT_W)) i_ph (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ph_load),
    .load_val (ph_val),
    .done     (ph_done)
  );

  bwc_line_match #(.ADDR_W(ADDR_W), .LINE_OFS(LINE_OFS)) i_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (accept),
    .cap_addr  (arm_addr),
    .watch     (watch),
    .hold      (hold),
    .inv_valid (inv_valid),
    .inv_addr  (inv_addr),
    .hit       (inv_hit),
    .pending   (inv_pend)
  );

  always_comb begin
    state_d = state_q;
    ph_load = 1'b0;
    ph_val  = arm_enter_lat;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        if (arm_stall == '0)  state_d = ST_SPIN;
        else if (arm_nosnoop) state_d = ST_FLUSH;
        else begin
          state_d = ST_ENTER;
          ph_load = 1'b1;
          ph_val  = arm_enter_lat;
        end
      end
      ST_FLUSH: if (flush_done) begin
        state_d = ST_ENTER;
        ph_load = 1'b1;
        ph_val  = ent_lat_q;
      end
      ST_ENTER: if (ph_done) state_d = ST_SLEEP;
      ST_SLEEP: if (wake) begin
        state_d = ST_EXIT;
        ph_load = 1'b1;
        ph_val  = ext_lat_q;
      end
      ST_EXIT:   if (ph_done) state_d = rel_flag ? ST_DEPART : ST_SPIN;
      ST_SPIN:   if (rel_flag) state_d = ST_DEPART;
      ST_DEPART: if (depart_ready) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      ent_lat_q <= '0;
      ext_lat_q <= '0;
      cause_q   <= '0;
      early_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        ent_lat_q <= arm_enter_lat;
        ext_lat_q <= arm_exit_lat;
        cause_q   <= '0;
        early_q   <= 1'b0;
      end
      if (wake) begin
        cause_q[CAUSE_TMR] <= wd_fire;
        cause_q[CAUSE_INV] <= inv_pend || inv_hit;
      end
      if (state_q == ST_EXIT && ph_done) early_q <= !rel_flag;
    end
  end

  assign arm_ready    = (state_q == ST_IDLE);
  assign flush_req    = (state_q == ST_FLUSH);
  assign core_sleep   = (state_q == ST_ENTER) || (state_q == ST_SLEEP);
  assign spinning     = (state_q == ST_SPIN);
  assign depart_valid = (state_q == ST_DEPART);
  assign wake_cause   = cause_q;
  assign early        = early_q;
endmodule

// File: rtl/bwc_checker.sv
module bwc_checker #(
  parameter int STALL_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               arm_valid,
  input logic               arm_ready,
  input logic [STALL_W-1:0] arm_stall,
  input logic               flush_req,
  input logic               flush_done,
  input logic               core_sleep,
  input logic               spinning,
  input logic               in_sleep,
  input logic               inv_hit,
  input logic               wd_fire,
  input logic [1:0]         wake_cause,
  input logic               depart_valid,
  input logic               depart_ready
);
  // R2
  arm_ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm_ready |-> !(depart_valid || flush_req || core_sleep || spinning));

  // R3
  zero_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_valid && arm_ready && arm_stall == '0) |=> (spinning && !flush_req && !core_sleep));

  // R4
  flush_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_req && !flush_done) |=> flush_req);

  // R6
  timer_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_fire |=> (!core_sleep && wake_cause[0]));

  // R7
  inv_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_hit && in_sleep) |=> (!core_sleep && wake_cause[1]));

  // R11
  depart_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (depart_valid && !depart_ready) |=> depart_valid);

  // R12
  cause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(arm_valid && arm_ready) && !in_sleep) |=> $stable(wake_cause));
endmodule

bind barrier_wake_ctrl bwc_checker #(.STALL_W(STALL_W)) i_bwc_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .arm_valid    (arm_valid),
  .arm_ready    (arm_ready),
  .arm_stall    (arm_stall),
  .flush_req    (flush_req),
  .flush_done   (flush_done),
  .core_sleep   (core_sleep),
  .spinning     (spinning),
  .in_sleep     (wd_run),
  .inv_hit      (inv_hit),
  .wd_fire      (wd_fire),
  .wake_cause   (wake_cause),
  .depart_valid (depart_valid),
  .depart_ready (depart_ready)
);

// File: tb/test_barrier_wake_ctrl.sv
`timescale 1ns/1ps
module test_barrier_wake_ctrl;
  localparam int STALL_W  = 3;
  localparam int ADDR_W   = 12;
  localparam int LINE_OFS = 4;
  localparam int LAT_W    = 1;
  localparam int FD       = 1;
  localparam logic [ADDR_W-1:0] LOCK  = 12'h5A4;
  localparam logic [ADDR_W-1:0] SAMEL = 12'h5AF;
  localparam logic [ADDR_W-1:0] OTHER = 12'h5B4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm_valid = 1'b0, arm_ready;
  logic [STALL_W-1:0] arm_stall = '0;
  logic [ADDR_W-1:0]  arm_addr = '0;
  logic arm_nosnoop = 1'b0;
  logic [LAT_W-1:0] arm_enter_lat = '0, arm_exit_lat = '0;
  logic flush_req, flush_done = 1'b0;
  logic inv_valid = 1'b0;
  logic [ADDR_W-1:0] inv_addr = '0;
  logic rel_flag = 1'b0;
  logic core_sleep, spinning, early, depart_valid, depart_ready = 1'b1;
  logic [1:0] wake_cause;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  barrier_wake_ctrl #(.STALL_W(STALL_W), .ADDR_W(ADDR_W), .LINE_OFS(LINE_OFS), .LAT_W(LAT_W))
  i_barrier_wake_ctrl (
    .clk(clk), .rst_n(rst_n), .arm_valid(arm_valid), .arm_ready(arm_ready),
    .arm_stall(arm_stall), .arm_addr(arm_addr), .arm_nosnoop(arm_nosnoop),
    .arm_enter_lat(arm_enter_lat), .arm_exit_lat(arm_exit_lat),
    .flush_req(flush_req), .flush_done(flush_done), .inv_valid(inv_valid),
    .inv_addr(inv_addr), .rel_flag(rel_flag), .core_sleep(core_sleep),
    .spinning(spinning), .wake_cause(wake_cause), .early(early),
    .depart_valid(depart_valid), .depart_ready(depart_ready)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one barrier; inv at cycle i (0 = none), kind i%3: 0 exact, 1 same line, 2 other line
  task automatic run(input int s, input int l, input int x, input int ns, input int i, input int r);
    int p, s0, w0, e_cause, e_early, e_dep, e_fl, e_sl;
    int dep, n_fl, n_sl, busy_bad, got_cause, got_early;
    bit hit;
    hit = (i > 0) && (i % 3 != 2);
    p  = 1 + (ns != 0 ? FD + 1 : 0);
    s0 = p + l + 1;
    if (s == 0) begin
      e_cause = 0; e_early = 0; e_dep = r + 1; e_fl = 0; e_sl = 0;
    end else begin
      if (hit && i <= s0 - 1) begin
        w0 = s0 + 1; e_cause = 2 + (s == 1 ? 1 : 0);
      end else if (hit && i >= s0 && i <= s0 + s - 1) begin
        w0 = i + 1; e_cause = 2 + (i == s0 + s - 1 ? 1 : 0);
      end else begin
        w0 = s0 + s; e_cause = 1;
      end
      e_early = (w0 + x < r) ? 1 : 0;
      e_dep   = (w0 + x + 1 > r + 1) ? w0 + x + 1 : r + 1;
      e_fl    = (ns != 0) ? FD + 1 : 0;
      e_sl    = (l + 1) + (w0 - s0);
    end
    dep = -1; n_fl = 0; n_sl = 0; busy_bad = 0; got_cause = -1; got_early = -1;
    for (int t = 0; t < 64; t++) begin
      @(negedge clk);
      arm_valid     = (t == 0);
      arm_stall     = STALL_W'(s);
      arm_addr      = LOCK;
      arm_nosnoop   = ns[0];
      arm_enter_lat = LAT_W'(l);
      arm_exit_lat  = LAT_W'(x);
      inv_valid     = (i > 0 && t == i);
      inv_addr      = (i % 3 == 0) ? LOCK : ((i % 3 == 1) ? SAMEL : OTHER);
      flush_done    = (ns != 0 && t == 1 + FD);
      rel_flag      = (t >= r);
      depart_ready  = 1'b1;
      #1;
      if (flush_req) n_fl++;
      if (core_sleep) n_sl++;
      if (depart_valid && dep < 0) dep = t;
      if (t > 0 && (dep < 0 || t == dep) && arm_ready) busy_bad++;
      if (dep >= 0 && t == dep + 1) begin
        got_cause = wake_cause; got_early = early;
        break;
      end
    end
    @(negedge clk);
    arm_valid = 1'b0; inv_valid = 1'b0; flush_done = 1'b0; rel_flag = 1'b0;
    chk(dep == e_dep, (s == 0) ? "R3 depart" : "R10 depart", dep, e_dep);
    chk(got_cause == e_cause, hit && i < s0 ? "R8 cause" : "R7 cause", got_cause, e_cause);
    chk(got_early == e_early, "R9 early", got_early, e_early);
    chk(n_fl == e_fl, "R4 flush cycles", n_fl, e_fl);
    chk(n_sl == e_sl, "R5 R6 sleep cycles", n_sl, e_sl);
    chk(busy_bad == 0, "R2 busy arm_ready", busy_bad, 0);
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(arm_ready == 1'b1, "R1 arm_ready", arm_ready, 1);
    chk({flush_req, core_sleep, spinning, depart_valid, early} == 5'b0, "R1 outputs",
        {flush_req, core_sleep, spinning, depart_valid, early}, 0);
    chk(wake_cause == 2'b00, "R1 wake_cause", wake_cause, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int s = 0; s < 8; s++)
      for (int l = 0; l < 2; l++)
        for (int x = 0; x < 2; x++)
          for (int ns = 0; ns < 2; ns++)
            for (int i = 0; i < 15; i++) begin
              run(s, l, x, ns, i, 1);
              run(s, l, x, ns, i, 30);
            end

    // R11 back-pressure on the departure token
    begin
      int held = 0;
      for (int t = 0; t < 40; t++) begin
        @(negedge clk);
        arm_valid = (t == 0); arm_stall = 3'd2; arm_addr = LOCK; arm_nosnoop = 1'b0;
        arm_enter_lat = 1'b0; arm_exit_lat = 1'b0; rel_flag = 1'b1;
        depart_ready = 1'b0;
        #1;
        if (depart_valid) held++;
        if (held == 4) break;
      end
      chk(held == 4, "R11 depart held", held, 4);
      chk(arm_ready == 1'b0, "R11 busy while held", arm_ready, 0);
      depart_ready = 1'b1;
      @(negedge clk); #1;
      chk(arm_ready == 1'b1 && !depart_valid, "R11 idle after take", arm_ready, 1);
      // R12 cause kept while idle
      chk(wake_cause == 2'b01, "R12 cause held", wake_cause, 1);
      repeat (3) @(negedge clk);
      chk(wake_cause == 2'b01, "R12 cause still held", wake_cause, 1);
      rel_flag = 1'b0;
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule